// File: doc/BRIEF.md
# Unaligned Write Read-Modify-Write Controller

This block turns byte-addressed write requests into command sequences for a word-wide SRAM that has no byte strobes. A requester presents a byte address, a 32-bit value and a size code. The block accepts the request when it is idle. It then drives the memory's read and write commands until every byte has landed in memory, and pulses a completion flag.

A 4-byte write on a word boundary covers the whole word, so it goes out as a single word write. Any other write must not disturb the bytes it does not cover. For those writes the block reads each affected word, waits one cycle for the data, replaces only the addressed byte lanes, and writes the word back. A write that crosses a word boundary is split into two such read-and-write passes. The pass for the lower-addressed word always goes first. Byte lanes are little-endian: byte offset k of a word sits in bits 8k+7 down to 8k.

Top module: `uwr_rmw_ctrl`

## Requirements
- R1: After reset, req_ready is high and mem_rd, mem_wr and done are all low.
- R2: The memory word address is the byte address shifted right by two bits; for example, byte 0x48C maps to word 0x123.
- R3: A 4-byte write (size code 2) at a byte address that is a multiple of four produces exactly one mem_wr, with no mem_rd, in the cycle after acceptance. The request data is written unchanged.
- R4: A 1-byte (size code 0) or 2-byte (size code 1) write that fits inside one word produces a read of that word. In the next cycle it produces a write to the same word, with the new bytes placed at lanes offset to offset+n-1 and every other byte kept from the read data.
- R5: A write that crosses a word boundary reads and writes back the lower word first, then reads and writes back the word at the next address. For example, 4 bytes at byte 0x48E replace the upper two bytes of word 0x123, then the lower two bytes of word 0x124.
- R6: Each merged write-back uses the mem_rdata value that is returned in the cycle after the matching read command, so that memory contents from earlier writes are preserved.
- R7: req_ready stays low from acceptance until the final write of the request has been issued. Requests presented while req_ready is low cause no memory command.
- R8: done is high for exactly one cycle: the cycle after the request's final write.
- R9: mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle; request is taken when valid and ready are both high |
| req_addr | input | 20 | Byte address |
| req_data | input | 32 | Write value; byte i of the request is bits 8i+7 to 8i |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: treated as 4 bytes |
| done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Memory read command; data returns the next cycle |
| mem_wr | output | 1 | Memory whole-word write command |
| mem_addr | output | 18 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after mem_rd |

## Verification
The bench first runs each byte lane of a word on its own. A lane shifted to the wrong position, or a merge that loses a neighbouring byte, would show up as a wrong write-back value or a corrupted final memory image. Straddling writes of 2 and 4 bytes at offsets 1 and 3 catch three faults: a controller that handles only one word, one that swaps the word order, or one that forgets to step the address. An aligned full word checks that the read is skipped, which catches a design that always reads first. A rewrite of bytes that were just written checks that the merge takes the fresh read data and not stale data. Requests held high during a busy sequence would cause extra memory commands if the block accepted them while busy. The bench also counts the cycles to done, which exposes a pulse that comes early, comes late, or lasts too long.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_FULL = 3'd1,
    ST_RD_LO   = 3'd2,
    ST_WB_LO   = 3'd3,
    ST_RD_HI   = 3'd4,
    ST_WB_HI   = 3'd5
  } uwr_state_e;

  // Number of bytes a size code stands for, clamped to the word width.
  function automatic int size_to_bytes(input logic [1:0] code, input int lanes);
    int n;
    n = 1 << code;
    if (n > lanes) n = lanes;
    return n;
  endfunction

  // Lane of a byte position inside a two-word window, given start offset.
  function automatic bit lane_covered(input int pos, input int off, input int nbytes);
    return (pos >= off) && (pos < off + nbytes);
  endfunction

endpackage

// File: rtl/uwr_plan.sv
module uwr_plan #(
  parameter int AW    = 20,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int WA_W  = AW - OFF_W,
  localparam int DW    = 8 * LANES
) (
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    data,
  input  logic [1:0]       size,
  output logic [WA_W-1:0]  base_word,
  output logic [LANES-1:0] lo_mask,
  output logic [LANES-1:0] hi_mask,
  output logic [DW-1:0]    lo_data,
  output logic [DW-1:0]    hi_data,
  output logic             full_word,
  output logic             straddle
);
  import uwr_pkg::*;

  logic [2*LANES-1:0] win_mask;
  logic [2*DW-1:0]    win_data;
  int                 off;
  int                 nbytes;

  assign base_word = addr[AW-1:OFF_W];

  always_comb begin
    off      = int'(addr[OFF_W-1:0]);
    nbytes   = size_to_bytes(size, LANES);
    win_mask = '0;
    win_data = '0;
    for (int j = 0; j < 2 * LANES; j++) begin
      if (lane_covered(j, off, nbytes)) begin
        win_mask[j]        = 1'b1;
        win_data[8*j +: 8] = data[8*(j - off) +: 8];
      end
    end
  end

  assign lo_mask   = win_mask[LANES-1:0];
  assign hi_mask   = win_mask[2*LANES-1:LANES];
  assign lo_data   = win_data[DW-1:0];
  assign hi_data   = win_data[2*DW-1:DW];
  assign straddle  = |hi_mask;
  assign full_word = &lo_mask;
endmodule

// File: rtl/uwr_merge.sv
module uwr_merge #(
  parameter int LANES = 4,
  localparam int DW = 8 * LANES
) (
  input  logic [DW-1:0]    old_word,
  input  logic [DW-1:0]    new_word,
  input  logic [LANES-1:0] lane_sel,
  output logic [DW-1:0]    merged
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[8*i +: 8] = lane_sel[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
  end
endmodule

// File: rtl/uwr_seq.sv
module uwr_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic full_in,
  input  logic straddle_q,
  output logic idle,
  output logic cmd_rd,
  output logic cmd_wr,
  output logic sel_hi,
  output logic last_wr,
  output logic done_q
);
  import uwr_pkg::*;

  uwr_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:    if (accept) state_nx = full_in ? ST_WR_FULL : ST_RD_LO;
      ST_WR_FULL: state_nx = ST_IDLE;
      ST_RD_LO:   state_nx = ST_WB_LO;
      ST_WB_LO:   state_nx = straddle_q ? ST_RD_HI : ST_IDLE;
      ST_RD_HI:   state_nx = ST_WB_HI;
      ST_WB_HI:   state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      state  <= state_nx;
      done_q <= last_wr;
    end
  end

  assign idle    = (state == ST_IDLE);
  assign cmd_rd  = (state == ST_RD_LO) || (state == ST_RD_HI);
  assign cmd_wr  = (state == ST_WR_FULL) || (state == ST_WB_LO) || (state == ST_WB_HI);
  assign sel_hi  = (state == ST_RD_HI) || (state == ST_WB_HI);
  assign last_wr = (state == ST_WR_FULL) || (state == ST_WB_HI) ||
                   ((state == ST_WB_LO) && !straddle_q);
endmodule

// File: rtl/uwr_rmw_ctrl.sv
module uwr_rmw_ctrl #(
  parameter int AW    = 20,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int WA_W  = AW - OFF_W,
  localparam int DW    = 8 * LANES
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_data,
  input  logic [1:0]      req_size,
  output logic            done,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [WA_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);
  // Named internal events, observed by the bound checker.
  logic evt_accept;
  logic evt_last_wr;

  logic [WA_W-1:0]  p_base;
  logic [LANES-1:0] p_lo_mask, p_hi_mask;
  logic [DW-1:0]    p_lo_data, p_hi_data;
  logic             p_full, p_straddle;

  logic [WA_W-1:0]  base_q;
  logic [LANES-1:0] lo_mask_q, hi_mask_q;
  logic [DW-1:0]    lo_data_q, hi_data_q;
  logic             straddle_q;

  logic idle, sel_hi, done_q;

  uwr_plan #(.AW(AW), .LANES(LANES)) u_plan (
    .addr      (req_addr),
    .data      (req_data),
    .size      (req_size),
    .base_word (p_base),
    .lo_mask   (p_lo_mask),
    .hi_mask   (p_hi_mask),
    .lo_data   (p_lo_data),
    .hi_data   (p_hi_data),
    .full_word (p_full),
    .straddle  (p_straddle)
  );

  assign evt_accept = req_valid && idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q     <= '0;
      lo_mask_q  <= '0;
      hi_mask_q  <= '0;
      lo_data_q  <= '0;
      hi_data_q  <= '0;
      straddle_q <= 1'b0;
    end else if (evt_accept) begin
      base_q     <= p_base;
      lo_mask_q  <= p_lo_mask;
      hi_mask_q  <= p_hi_mask;
      lo_data_q  <= p_lo_data;
      hi_data_q  <= p_hi_data;
      straddle_q <= p_straddle;
    end
  end

  uwr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (evt_accept),
    .full_in    (p_full),
    .straddle_q (straddle_q),
    .idle       (idle),
    .cmd_rd     (mem_rd),
    .cmd_wr     (mem_wr),
    .sel_hi     (sel_hi),
    .last_wr    (evt_last_wr),
    .done_q     (done_q)
  );

  // A full-word write has an all-ones low mask, so the merge passes new data.
  uwr_merge #(.LANES(LANES)) u_merge (
    .old_word (mem_rdata),
    .new_word (sel_hi ? hi_data_q : lo_data_q),
    .lane_sel (sel_hi ? hi_mask_q : lo_mask_q),
    .merged   (mem_wdata)
  );

  assign mem_addr  = sel_hi ? base_q + 1'b1 : base_q;
  assign req_ready = idle;
  assign done      = done_q;
endmodule

// File: rtl/uwr_rmw_chk.sv
module uwr_rmw_chk #(
  parameter int AW    = 20,
  parameter int LANES = 4,
  localparam int OFF_W = $clog2(LANES),
  localparam int WA_W  = AW - OFF_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [1:0]      req_size,
  input logic            done,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic [WA_W-1:0] mem_addr,
  input logic            evt_last_wr
);
  import uwr_pkg::*;

  logic aligned_full_req;
  assign aligned_full_req = req_valid && req_ready &&
                            (size_to_bytes(req_size, LANES) == LANES) &&
                            (req_addr[OFF_W-1:0] == '0);

  AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R9

  AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (mem_wr && mem_addr == $past(mem_addr))); // R6

  AST_HI_WORD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && $past(mem_wr)) |-> (mem_addr == WA_W'($past(mem_addr) + 1'b1))); // R5

  AST_FULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    aligned_full_req |=> (mem_wr && !mem_rd)); // R3

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> !req_ready); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    evt_last_wr |=> done); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind uwr_rmw_ctrl uwr_rmw_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .req_size    (req_size),
  .done        (done),
  .mem_rd      (mem_rd),
  .mem_wr      (mem_wr),
  .mem_addr    (mem_addr),
  .evt_last_wr (evt_last_wr)
);

// File: tb/uwr_rmw_ctrl_tb.sv
module uwr_rmw_ctrl_tb;
  localparam int MEMW = 512;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic [1:0]  req_size = '0;
  logic        done;
  logic        mem_rd, mem_wr;
  logic [17:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  typedef struct {
    bit          is_wr;
    logic [17:0] addr;
    logic [31:0] data;
    string       tag;
  } op_t;

  op_t         exp_q[$];
  logic [31:0] sram[MEMW];
  logic [31:0] ref_mem[MEMW];

  uwr_rmw_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .req_size  (req_size),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  always #4 clk = ~clk;

  // SRAM model: one-cycle read latency, whole-word writes only.
  always @(posedge clk) begin
    if (mem_wr) sram[mem_addr[8:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= sram[mem_addr[8:0]];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare every memory command against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && (mem_rd || mem_wr)) begin
      check(!(mem_rd && mem_wr), "R9 rd and wr together", {30'b0, mem_rd, mem_wr}, 32'h2);
      check(!req_ready, "R7 ready during memory command", {31'b0, req_ready}, 32'h0);
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected memory command", {14'b0, mem_addr}, 32'h0);
      end else begin
        op_t e;
        e = exp_q.pop_front();
        check(mem_wr == e.is_wr, {e.tag, " command kind"}, {31'b0, mem_wr}, {31'b0, e.is_wr});
        check(mem_addr == e.addr, {e.tag, " word address"}, {14'b0, mem_addr}, {14'b0, e.addr});
        if (e.is_wr)
          check(mem_wdata == e.data, {e.tag, " write data"}, mem_wdata, e.data);
      end
    end
  end

  task automatic push_op(input bit w, input logic [17:0] a, input logic [31:0] d, input string tag);
    op_t o;
    o.is_wr = w; o.addr = a; o.data = d; o.tag = tag;
    exp_q.push_back(o);
  endtask

  task automatic do_write(input logic [19:0] a, input logic [31:0] d, input logic [1:0] sz,
                          input bit noise, input string tag);
    int          nb;
    int          nops;
    int          k;
    logic [19:0] last_b;
    nb = 1 << sz;
    nops = 0;
    last_b = a + 20'(nb - 1);
    if (nb == 4 && a[1:0] == 2'b00) begin
      push_op(1'b1, a[19:2], d, tag);
      ref_mem[a[10:2]] = d;
      nops = 1;
    end else begin
      for (logic [17:0] w = a[19:2]; w <= last_b[19:2]; w++) begin
        logic [31:0] word;
        push_op(1'b0, w, 32'h0, tag);
        word = ref_mem[w[8:0]];
        for (int i = 0; i < nb; i++) begin
          logic [19:0] ba;
          ba = a + 20'(i);
          if (ba[19:2] == w) word[8*ba[1:0] +: 8] = d[8*i +: 8];
        end
        push_op(1'b1, w, word, tag);
        ref_mem[w[8:0]] = word;
        nops += 2;
      end
    end
    @(negedge clk);
    check(req_ready, {tag, " ready before request"}, {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_addr = a; req_data = d; req_size = sz;
    @(posedge clk);
    k = 0;
    while (k < 20) begin
      @(negedge clk);
      k++;
      if (noise && k <= nops) begin
        req_valid = 1'b1; req_addr = 20'h00010; req_data = 32'hDEADBEEF; req_size = 2'd2;
      end else begin
        req_valid = 1'b0;
      end
      if (done) break;
    end
    req_valid = 1'b0;
    check(k == nops + 1, "R8 done cycle after final write", 32'(k), 32'(nops + 1));
    @(negedge clk);
    check(!done, "R8 done lasts one cycle", {31'b0, done}, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < MEMW; i++) begin
      sram[i]    = 32'(i) * 32'h9E3779B1;
      ref_mem[i] = 32'(i) * 32'h9E3779B1;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
    check({mem_rd, mem_wr, done} == 3'b000, "R1 idle outputs after reset",
          {29'b0, mem_rd, mem_wr, done}, 32'h0);
    rst_n = 1'b1;

    do_write(20'h0048C, 32'hCAFEF00D, 2'd2, 1'b0, "R2,R3 aligned word");
    do_write(20'h0048E, 32'h11223344, 2'd2, 1'b0, "R5 straddle word");
    for (int l = 0; l < 4; l++)
      do_write(20'h00100 + 20'(l), 32'h000000A0 + 32'(l), 2'd0, 1'b0, "R4 byte lane");
    do_write(20'h00201, 32'h0000BEEF, 2'd1, 1'b0, "R4 half inside");
    do_write(20'h00202, 32'h00005A5A, 2'd1, 1'b0, "R4 half upper");
    do_write(20'h00203, 32'h0000C3C3, 2'd1, 1'b0, "R5 straddle half");
    do_write(20'h00301, 32'h01020304, 2'd2, 1'b0, "R5 word offset1");
    do_write(20'h00307, 32'hA1B2C3D4, 2'd2, 1'b0, "R5 word offset3");
    do_write(20'h00405, 32'h55667788, 2'd2, 1'b1, "R7 busy straddle");
    do_write(20'h00050, 32'h0BADCAFE, 2'd2, 1'b1, "R7 busy aligned");
    do_write(20'h0048D, 32'h00009911, 2'd1, 1'b0, "R6 reread fresh");
    do_write(20'h0048F, 32'h000000EE, 2'd0, 1'b0, "R6 reread byte");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all expected commands seen", 32'(exp_q.size()), 32'h0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < MEMW; i++) if (sram[i] !== ref_mem[i]) bad++;
      check(bad == 0, "R4 untouched bytes preserved in memory image", 32'(bad), 32'h0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule